// File: doc/BRIEF.md
# Stored-Image Reconfiguration Sequencer

This block steers a reconfiguration engine through loading one of several stored configuration images into its scan cache. Once the clock generator reports lock, the block sits idle until it sees a single-cycle load request together with an image number. It then registers that number, points an image multiplexer at the chosen stored word, and raises a one-cycle write-from-memory strobe. After that it waits for the engine to finish and closes the sequence with a one-cycle reconfigure pulse.

The current step of the sequence is visible on a numeric state output, so the progress of a load can be watched from outside. The stored images arrive as one flat input vector. The engine and the clock generator are not part of this block.

Top module: `cfg_image_loader`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `state_code` is 0, `load_strobe` and `reconfig_pulse` are low, and the captured image number is cleared, so `eng_data` shows image 0.
- R2: While `pll_locked` is low, a request seen in state 0 is ignored: the state stays 0 and no strobe is issued.
- R3: When a clock edge finds state 0 with `pll_locked` high and `load_req` high, `state_code` reads 1 and `load_strobe` is high in the next cycle.
- R4: `load_strobe` is high for exactly one cycle. State 1 is always followed by state 2.
- R5: `eng_data` equals image word k, taken from `img_data[k*DATA_W +: DATA_W]`, where k is the image number captured at the accepting edge.
- R6: The captured image number changes only on an accepted request. Changes on `img_sel` at any other time leave `eng_data` unchanged.
- R7: The block stays in state 2 for as long as `eng_busy` is high. At the first edge that finds `eng_busy` low in state 2, it moves to state 3.
- R8: State 3 lasts one cycle with `reconfig_pulse` high, and the block then returns to state 0.
- R9: A request that arrives while the state is not 0 is ignored: no extra strobe is issued and the captured image number is kept.
- R10: The state codes are 0 idle, 1 load, 2 wait-for-engine and 3 reconfigure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_locked | input | 1 | Lock indication from the clock generator |
| load_req | input | 1 | Single-cycle load request |
| img_sel | input | SEL_W | Image number, valid with `load_req` |
| img_data | input | IMG_COUNT*DATA_W | All stored image words, word k at bits k*DATA_W |
| eng_busy | input | 1 | Engine busy indication |
| eng_data | output | DATA_W | Selected image word to the engine data input |
| load_strobe | output | 1 | Write-from-memory strobe |
| reconfig_pulse | output | 1 | One-cycle reconfigure command |
| state_code | output | 2 | Current sequencer state code |

## Verification
If the captured image number were wrong, `eng_data` would show the wrong word in the same cycle that `load_strobe` rises. The scoreboard catches this at that strobe. A state register that leaves state 0 by mistake shows up on the next edge as a stray strobe or a wrong `state_code`. One that stalls in the wait state is caught by the count of wait cycles against the busy length the engine model uses. A request that is not ignored outside state 0 appears within one cycle as a strobe the scoreboard never expected.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

   localparam int STATE_W = 2;

   typedef enum logic [STATE_W-1:0] {
      ST_IDLE  = 2'd0,
      ST_LOAD  = 2'd1,
      ST_WAIT  = 2'd2,
      ST_PULSE = 2'd3
   } ld_state_t;

endpackage

// File: rtl/cfg_load_fsm.sv
module cfg_load_fsm
   import cfg_loader_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      locked,
   input  logic      req,
   input  logic      busy,
   output ld_state_t state_q,
   output logic      accept
);

   ld_state_t state_d;

   assign accept = (state_q == ST_IDLE) && req && locked;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (accept) state_d = ST_LOAD;
         ST_LOAD:  state_d = ST_WAIT;
         ST_WAIT:  if (!busy) state_d = ST_PULSE;
         ST_PULSE: state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   // R3
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && req && locked) |=> (state_q == ST_LOAD));

   // R2
   no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !locked) |=> (state_q == ST_IDLE));

   // R4
   load_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LOAD) |=> (state_q == ST_WAIT));

   // R7
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && busy) |=> (state_q == ST_WAIT));

   // R8
   pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PULSE) |=> (state_q == ST_IDLE));

   // R9
   ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |=> (state_q != ST_LOAD));

endmodule

// File: rtl/cfg_sel_capture.sv
module cfg_sel_capture #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [SEL_W-1:0] sel_in,
   output logic [SEL_W-1:0] sel_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sel_q <= '0;
      else if (capture) sel_q <= sel_in;
   end

endmodule

// File: rtl/cfg_image_mux.sv
module cfg_image_mux #(
   parameter int IMG_COUNT  = 4,
   parameter int DATA_W     = 8,
   parameter int SEL_W      = 2,
   parameter bit MUX_AND_OR = 1'b0
) (
   input  logic [IMG_COUNT*DATA_W-1:0] img_flat,
   input  logic [SEL_W-1:0]            sel,
   output logic [DATA_W-1:0]           word_out
);

   localparam int SLOTS = 1 << SEL_W;

   generate
      if (MUX_AND_OR) begin : g_and_or
         logic [IMG_COUNT-1:0] hit;
         always_comb begin
            for (int k = 0; k < IMG_COUNT; k++)
               hit[k] = (sel == SEL_W'(k));
         end
         always_comb begin
            word_out = '0;
            for (int k = 0; k < IMG_COUNT; k++)
               word_out = word_out | ({DATA_W{hit[k]}} & img_flat[k*DATA_W +: DATA_W]);
         end
      end else begin : g_indexed
         logic [DATA_W-1:0] slot [SLOTS];
         for (genvar k = 0; k < SLOTS; k++) begin : g_slot
            if (k < IMG_COUNT) begin : g_used
               assign slot[k] = img_flat[k*DATA_W +: DATA_W];
            end else begin : g_spare
               assign slot[k] = '0;
            end
         end
         assign word_out = slot[sel];
      end
   endgenerate

endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
   import cfg_loader_pkg::*;
#(
   parameter int IMG_COUNT  = 4,
   parameter int DATA_W     = 8,
   parameter bit MUX_AND_OR = 1'b0,
   localparam int SEL_W     = (IMG_COUNT > 1) ? $clog2(IMG_COUNT) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        pll_locked,
   input  logic                        load_req,
   input  logic [SEL_W-1:0]            img_sel,
   input  logic [IMG_COUNT*DATA_W-1:0] img_data,
   input  logic                        eng_busy,
   output logic [DATA_W-1:0]           eng_data,
   output logic                        load_strobe,
   output logic                        reconfig_pulse,
   output logic [STATE_W-1:0]          state_code
);

   generate
      if (IMG_COUNT < 2 || IMG_COUNT > 4) begin : g_bad_count
         $error("cfg_image_loader: IMG_COUNT must be 2..4");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("cfg_image_loader: DATA_W must be at least 1");
      end
   endgenerate

   ld_state_t        fsm_state;
   logic             accept;
   logic [SEL_W-1:0] sel_q;

   cfg_load_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .locked  (pll_locked),
      .req     (load_req),
      .busy    (eng_busy),
      .state_q (fsm_state),
      .accept  (accept)
   );

   cfg_sel_capture #(.SEL_W(SEL_W)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (accept),
      .sel_in  (img_sel),
      .sel_q   (sel_q)
   );

   cfg_image_mux #(
      .IMG_COUNT  (IMG_COUNT),
      .DATA_W     (DATA_W),
      .SEL_W      (SEL_W),
      .MUX_AND_OR (MUX_AND_OR)
   ) u_mux (
      .img_flat (img_data),
      .sel      (sel_q),
      .word_out (eng_data)
   );

   assign load_strobe    = (fsm_state == ST_LOAD);
   assign reconfig_pulse = (fsm_state == ST_PULSE);
   assign state_code     = fsm_state;

   // R6
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_state != ST_IDLE) |=> $stable(sel_q));

   // R4
   strobe_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_strobe |=> !load_strobe);

   // R8
   pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reconfig_pulse |=> !reconfig_pulse);

endmodule

// File: tb/cfg_image_loader_tb_top.sv
module cfg_image_loader_tb_top;

   localparam int IMG_COUNT = 4;
   localparam int DATA_W    = 8;
   localparam int SEL_W     = 2;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic                        rst_n;
   logic                        pll_locked;
   logic                        load_req;
   logic [SEL_W-1:0]            img_sel;
   logic [IMG_COUNT*DATA_W-1:0] img_data;
   logic                        eng_busy;
   logic [DATA_W-1:0]           eng_data;
   logic                        load_strobe;
   logic                        reconfig_pulse;
   logic [1:0]                  state_code;

   cfg_image_loader #(.IMG_COUNT(IMG_COUNT), .DATA_W(DATA_W)) dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .pll_locked     (pll_locked),
      .load_req       (load_req),
      .img_sel        (img_sel),
      .img_data       (img_data),
      .eng_busy       (eng_busy),
      .eng_data       (eng_data),
      .load_strobe    (load_strobe),
      .reconfig_pulse (reconfig_pulse),
      .state_code     (state_code)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   logic [DATA_W-1:0] exp_q [$];

   // engine model: busy for busy_len cycles after the strobe
   int busy_len = 0;
   int busy_cnt = 0;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n)                busy_cnt <= 0;
      else if (load_strobe)      busy_cnt <= busy_len;
      else if (busy_cnt != 0)    busy_cnt <= busy_cnt - 1;
   end
   assign eng_busy = (busy_cnt != 0);

   function automatic logic [DATA_W-1:0] word_of(int k);
      return DATA_W'(8'h5A ^ (k * 37 + 3));
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && load_strobe) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R9 unexpected strobe", 1, 0);
         end else begin
            logic [DATA_W-1:0] e;
            e = exp_q.pop_front();
            check(eng_data == e, "R5 data at strobe", int'(eng_data), int'(e));
            check(state_code == 2'd1, "R10 code at strobe", int'(state_code), 1);
         end
      end
   end

   task automatic run_load(int sel, int blen);
      int n;
      busy_len = blen;
      @(negedge clk);
      load_req = 1'b1;
      img_sel  = SEL_W'(sel);
      exp_q.push_back(word_of(sel));
      @(negedge clk);
      load_req = 1'b0;
      img_sel  = SEL_W'(sel ^ 1);
      check(state_code == 2'd1 && load_strobe, "R3 accept", int'(state_code), 1);
      @(negedge clk);
      check(state_code == 2'd2 && !load_strobe, "R4 strobe single", int'(state_code), 2);
      check(eng_data == word_of(sel), "R6 held select", int'(eng_data), int'(word_of(sel)));
      n = 1;
      while (state_code == 2'd2) begin
         @(negedge clk);
         if (state_code == 2'd2) n++;
      end
      check(n == blen + 1, "R7 wait length", n, blen + 1);
      check(state_code == 2'd3 && reconfig_pulse, "R8 pulse", int'(state_code), 3);
      @(negedge clk);
      check(state_code == 2'd0 && !reconfig_pulse, "R8 back to idle", int'(state_code), 0);
      check(eng_data == word_of(sel), "R5 data after load", int'(eng_data), int'(word_of(sel)));
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         check(1'b0, "watchdog expired", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      rst_n      = 1'b0;
      pll_locked = 1'b0;
      load_req   = 1'b0;
      img_sel    = '0;
      for (int k = 0; k < IMG_COUNT; k++) img_data[k*DATA_W +: DATA_W] = word_of(k);
      repeat (3) @(negedge clk);
      // R1
      check(state_code == 2'd0, "R1 reset state", int'(state_code), 0);
      check(!load_strobe && !reconfig_pulse, "R1 strobes low", int'({load_strobe, reconfig_pulse}), 0);
      check(eng_data == word_of(0), "R1 image 0", int'(eng_data), int'(word_of(0)));
      rst_n = 1'b1;

      // R2: no lock, request ignored
      @(negedge clk);
      load_req = 1'b1;
      img_sel  = 2'd2;
      @(negedge clk);
      load_req = 1'b0;
      check(state_code == 2'd0 && !load_strobe, "R2 no lock ignore", int'(state_code), 0);
      @(negedge clk);
      check(eng_data == word_of(0), "R2 select kept", int'(eng_data), int'(word_of(0)));
      pll_locked = 1'b1;

      run_load(2, 3);
      run_load(0, 0);
      run_load(3, 1);
      run_load(1, 5);

      // R6: select change in idle
      @(negedge clk);
      img_sel = 2'd3;
      repeat (2) @(negedge clk);
      check(eng_data == word_of(1), "R6 idle select change", int'(eng_data), int'(word_of(1)));

      // R9: requests during load and wait states
      busy_len = 4;
      @(negedge clk);
      load_req = 1'b1;
      img_sel  = 2'd2;
      exp_q.push_back(word_of(2));
      @(negedge clk);
      img_sel = 2'd0;
      @(negedge clk);
      load_req = 1'b0;
      @(negedge clk);
      load_req = 1'b1;
      img_sel  = 2'd3;
      @(negedge clk);
      load_req = 1'b0;
      repeat (10) @(negedge clk);
      check(state_code == 2'd0, "R9 settled idle", int'(state_code), 0);
      check(eng_data == word_of(2), "R9 select kept", int'(eng_data), int'(word_of(2)));
      check(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);

      // R1: reset in the middle of a load
      busy_len = 6;
      @(negedge clk);
      load_req = 1'b1;
      img_sel  = 2'd3;
      exp_q.push_back(word_of(3));
      @(negedge clk);
      load_req = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(state_code == 2'd0 && !load_strobe && !reconfig_pulse, "R1 async reset", int'(state_code), 0);
      check(eng_data == word_of(0), "R1 select cleared", int'(eng_data), int'(word_of(0)));
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule